// File: doc/BRIEF.md
# Codec Link Reset and Presence Detect Sequencer

This block runs the timed reset of an audio codec link on behalf of a controller. When it is started with a full reset requested, it first pulses a clear strobe that writes ones to the controller's state-change status bits. It then drops the controller's run bit and waits for the controller to report that the link is in reset. After a codec PLL settle interval it sets the run bit again and waits for the controller to report that it is running. After a further codec initialisation interval it checks whether the controller is ready.

When started without a full reset, the sequencer goes straight to the ready check. If the controller is not ready at the check, the sequence ends with a busy error. Otherwise the codec presence mask is loaded from the 15-bit state-change status input, but only if the mask is still zero, so the first non-zero detection is kept. Each readback poll gives up after 100 ms. A poll that times out raises a sticky timeout flag, and the sequence carries on. All intervals are cycle counts derived from the clock frequency parameter.

Top module: `link_reset_seq`

## Requirements
- R1: After a synchronous reset, link_run_o, stat_clr_o, done_o, busy_err_o and tmo_o are 0 and codec_mask_o is all zeros.
- R2: A start_i seen in idle with full_rst_i=1 makes stat_clr_o high for exactly one cycle, the first cycle after the start edge. link_run_o is 0 from that same cycle.
- R3: Once rst_rdbk_i reads 0 in the reset phase, link_run_o stays 0 for at least SETTLE_CYC = CLK_HZ/10000 cycles and rises no later than SETTLE_CYC+3 cycles after that sample.
- R4: If rst_rdbk_i does not reach the level a poll waits for (0 in the reset phase, 1 in the run phase) within TMO_CYC = CLK_HZ/10 cycles, tmo_o is set to 1 and the sequence continues to completion. tmo_o is cleared by the next start.
- R5: After rst_rdbk_i reads 1 in the run phase, done_o comes no earlier than INIT_CYC = (CLK_HZ/100000)*54 cycles later and no later than INIT_CYC+4 cycles later.
- R6: At the ready check, rst_rdbk_i=1 means the controller is ready. If it is not ready, busy_err_o is 1 in the same cycle as done_o. If it is ready, busy_err_o is 0. busy_err_o holds its value until the next start.
- R7: At a ready check that finds the controller ready, codec_mask_o is loaded from stat_i (bit n = codec n) if codec_mask_o is all zeros. Otherwise codec_mask_o is left unchanged.
- R8: A start with full_rst_i=0 produces no stat_clr_o pulse and leaves link_run_o unchanged. done_o is seen within 3 cycles of the start.
- R9: done_o is a one-cycle pulse, given once per sequence. A start_i asserted while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a sequence when the sequencer is idle |
| full_rst_i | input | 1 | 1 runs the timed link reset, 0 goes straight to the ready check |
| rst_rdbk_i | input | 1 | Controller reset readback: 0 means the link is in reset, 1 means it is running/ready |
| stat_i | input | NCODEC | Codec state-change status, one bit per codec |
| link_run_o | output | 1 | Controller run bit: 0 holds the link in reset |
| stat_clr_o | output | 1 | One-cycle strobe that clears all state-change status bits by writing ones |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| busy_err_o | output | 1 | Controller was not ready at the last check |
| tmo_o | output | 1 | Sticky flag: a readback poll timed out |
| codec_mask_o | output | NCODEC | Latched codec presence mask |

## Verification
All outputs are registered. The strobe and the drop of the run bit are therefore due in the first sample after the start edge, and a skipped sequence reports done in the second sample. The timed phases are not checked against one exact cycle. Instead, the bench timestamps the sample where the readback first reaches the level a poll waits for. It then requires the next output edge to fall inside the window that the requirement gives: settle interval plus up to three cycles of register and timer latency before the run bit rises, and initialisation interval plus up to four cycles before done. The bench reads flags and the mask a few cycles after done, when they must be held.

// File: rtl/lrs_pkg.sv
`timescale 1ns/1ps
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_SETTLE,
    ST_EXIT,
    ST_INIT,
    ST_CHECK
  } lrs_state_e;
endpackage

// File: rtl/lrs_delay_timer.sv
`timescale 1ns/1ps
module lrs_delay_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          exp_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == '0);

  AST_TMR_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/lrs_mask_latch.sv
`timescale 1ns/1ps
module lrs_mask_latch #(
  parameter int NCODEC = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [NCODEC-1:0] stat_i,
  output logic [NCODEC-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)                          mask_o <= '0;
    else if (cap_i && mask_o == '0)   mask_o <= stat_i;
  end

  AST_MASK_ONCE: assert property (@(posedge clk) disable iff (rst)
    (mask_o != '0) |=> $stable(mask_o)); // R7
endmodule

// File: rtl/lrs_ctrl.sv
`timescale 1ns/1ps
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int CW     = 16,
  parameter int TMO_N  = 1000,
  parameter int SET_N  = 10,
  parameter int INIT_N = 54
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          full_i,
  input  logic          rdbk_i,
  input  logic          tmr_exp_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          cap_o,
  output logic          link_run_o,
  output logic          stat_clr_o,
  output logic          done_o,
  output logic          busy_err_o,
  output logic          tmo_o
);
  localparam logic [CW-1:0] TMO_V  = CW'(TMO_N);
  localparam logic [CW-1:0] SET_V  = CW'(SET_N);
  localparam logic [CW-1:0] INIT_V = CW'(INIT_N);

  lrs_state_e state_q;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = TMO_V;
    unique case (state_q)
      ST_IDLE:   if (start_i && full_i) begin tmr_load_o = 1'b1; tmr_val_o = TMO_V; end
      ST_ENTER:  if (!rdbk_i || tmr_exp_i) begin tmr_load_o = 1'b1; tmr_val_o = SET_V; end
      ST_SETTLE: if (tmr_exp_i) begin tmr_load_o = 1'b1; tmr_val_o = TMO_V; end
      ST_EXIT:   if (rdbk_i || tmr_exp_i) begin tmr_load_o = 1'b1; tmr_val_o = INIT_V; end
      default: ;
    endcase
  end

  assign cap_o = (state_q == ST_CHECK) && rdbk_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      link_run_o <= 1'b0;
      stat_clr_o <= 1'b0;
      done_o     <= 1'b0;
      busy_err_o <= 1'b0;
      tmo_o      <= 1'b0;
    end else begin
      stat_clr_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          busy_err_o <= 1'b0;
          tmo_o      <= 1'b0;
          if (full_i) begin
            stat_clr_o <= 1'b1;
            link_run_o <= 1'b0;
            state_q    <= ST_ENTER;
          end else begin
            state_q <= ST_CHECK;
          end
        end
        ST_ENTER: if (!rdbk_i || tmr_exp_i) begin
          if (rdbk_i) tmo_o <= 1'b1;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp_i) begin
          link_run_o <= 1'b1;
          state_q    <= ST_EXIT;
        end
        ST_EXIT: if (rdbk_i || tmr_exp_i) begin
          if (!rdbk_i) tmo_o <= 1'b1;
          state_q <= ST_INIT;
        end
        ST_INIT: if (tmr_exp_i) state_q <= ST_CHECK;
        ST_CHECK: begin
          done_o     <= 1'b1;
          busy_err_o <= !rdbk_i;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_SKIP_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && !full_i) |=> !stat_clr_o); // R8
  AST_HOLD_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |-> !link_run_o); // R3
  AST_BUSY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_err_o) |-> done_o); // R6
  AST_CLR_ENTER: assert property (@(posedge clk) disable iff (rst)
    stat_clr_o |-> (state_q == ST_ENTER && !link_run_o)); // R2
endmodule

// File: rtl/link_reset_seq.sv
`timescale 1ns/1ps
module link_reset_seq #(
  parameter int CLK_HZ = 100_000_000,
  parameter int NCODEC = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              full_rst_i,
  input  logic              rst_rdbk_i,
  input  logic [NCODEC-1:0] stat_i,
  output logic              link_run_o,
  output logic              stat_clr_o,
  output logic              done_o,
  output logic              busy_err_o,
  output logic              tmo_o,
  output logic [NCODEC-1:0] codec_mask_o
);
  localparam int TMO_CYC    = CLK_HZ / 10;
  localparam int SETTLE_CYC = CLK_HZ / 10000;
  localparam int INIT_CYC   = (CLK_HZ / 100000) * 54;
  localparam int CW         = $clog2(TMO_CYC + 1);

  logic          tmr_load, tmr_exp, cap;
  logic [CW-1:0] tmr_val;

  lrs_ctrl #(
    .CW(CW), .TMO_N(TMO_CYC), .SET_N(SETTLE_CYC), .INIT_N(INIT_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .full_i     (full_rst_i),
    .rdbk_i     (rst_rdbk_i),
    .tmr_exp_i  (tmr_exp),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .cap_o      (cap),
    .link_run_o (link_run_o),
    .stat_clr_o (stat_clr_o),
    .done_o     (done_o),
    .busy_err_o (busy_err_o),
    .tmo_o      (tmo_o)
  );

  lrs_delay_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .exp_o  (tmr_exp)
  );

  lrs_mask_latch #(.NCODEC(NCODEC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .stat_i (stat_i),
    .mask_o (codec_mask_o)
  );
endmodule

// File: tb/link_reset_seq_test.sv
`timescale 1ns/1ps
module link_reset_seq_test;
  localparam int HZ  = 100_000;
  localparam int NC  = 15;
  localparam int TMO = HZ / 10;
  localparam int SET = HZ / 10000;
  localparam int INI = (HZ / 100000) * 54;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, full = 1'b0, rdbk = 1'b0;
  logic [NC-1:0] stat = '0;
  logic link_run, stat_clr, done, busy_err, tmo;
  logic [NC-1:0] mask;

  int checks = 0, fails = 0;
  int dly = 0;
  bit stuck_hi = 0, stuck_lo = 0, finished = 0;
  logic [31:0] hist = '0;
  logic [NC-1:0] exp_m = '0;

  always #2.5 clk = ~clk;

  link_reset_seq #(.CLK_HZ(HZ), .NCODEC(NC)) uut (
    .clk(clk), .rst(rst), .start_i(start), .full_rst_i(full),
    .rst_rdbk_i(rdbk), .stat_i(stat), .link_run_o(link_run),
    .stat_clr_o(stat_clr), .done_o(done), .busy_err_o(busy_err),
    .tmo_o(tmo), .codec_mask_o(mask)
  );

  // controller model: readback follows the run bit after dly cycles
  initial forever begin
    @(negedge clk);
    hist = {hist[30:0], link_run};
    rdbk = stuck_hi ? 1'b1 : (stuck_lo ? 1'b0 : hist[dly]);
  end

  function automatic logic [NC-1:0] next_mask(logic [NC-1:0] cur, logic [NC-1:0] st, bit ready);
    return (ready && cur == '0) ? st : cur;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  int t_low, t_rise, t_high, t_done, clr_cnt, clr_first, done_cnt;
  logic lr1, lr_before;

  task automatic run_seq(bit f, bit mid);
    t_low = -1; t_rise = -1; t_high = -1; t_done = -1;
    clr_cnt = 0; clr_first = -1; done_cnt = 0; lr1 = 1'bx;
    @(negedge clk); #1;
    lr_before = link_run;
    start = 1'b1; full = f;
    for (int cyc = 1; cyc < 25000; cyc++) begin
      @(negedge clk); #1;
      if (cyc == 1) begin start = 1'b0; lr1 = link_run; end
      if (mid && cyc == 20) start = 1'b1;
      if (mid && cyc == 21) start = 1'b0;
      if (stat_clr) begin clr_cnt++; if (clr_first < 0) clr_first = cyc; end
      if (f && t_low < 0 && !rdbk && !link_run) t_low = cyc;
      if (t_low >= 0 && t_rise < 0 && link_run) t_rise = cyc;
      if (t_rise >= 0 && t_high < 0 && rdbk) t_high = cyc;
      if (done) begin done_cnt++; if (t_done < 0) t_done = cyc; end
      if (t_done >= 0 && cyc >= t_done + 6) break;
    end
  endtask

  task automatic check_full_normal(string tag);
    chk(clr_cnt == 1 && clr_first == 1, "R2", {tag, " clear strobe cycles"}, clr_cnt, 1);
    chk(lr1 == 1'b0, "R2", {tag, " run bit after start"}, lr1, 0);
    chk(t_rise - t_low >= SET && t_rise - t_low <= SET + 3, "R3",
        {tag, " settle gap"}, t_rise - t_low, SET);
    chk(t_high >= 0 && t_done - t_high >= INI && t_done - t_high <= INI + 4, "R5",
        {tag, " init gap"}, t_done - t_high, INI);
    chk(tmo == 1'b0, "R4", {tag, " no timeout"}, tmo, 0);
    chk(busy_err == 1'b0, "R6", {tag, " ready no busy"}, busy_err, 0);
    chk(done_cnt == 1, "R9", {tag, " single done"}, done_cnt, 1);
    chk(link_run == 1'b1, "R3", {tag, " run bit released"}, link_run, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(link_run == 0 && stat_clr == 0 && done == 0 && busy_err == 0 && tmo == 0,
        "R1", "control outputs after reset", {link_run, stat_clr, done, busy_err, tmo}, 0);
    chk(mask == '0, "R1", "mask after reset", mask, 0);

    // skip path before any full reset: controller not ready
    run_seq(1'b0, 1'b0);
    chk(clr_cnt == 0, "R8", "skip no clear strobe", clr_cnt, 0);
    chk(t_done >= 1 && t_done <= 3, "R8", "skip done latency", t_done, 2);
    chk(busy_err == 1'b1, "R6", "not ready gives busy", busy_err, 1);
    chk(mask == '0, "R7", "mask untouched when not ready", mask, 0);

    // full reset with zero status: mask stays zero
    dly = 3; stat = '0;
    run_seq(1'b1, 1'b0);
    check_full_normal("first");
    chk(mask == '0, "R7", "zero status latched as zero", mask, 0);

    // random mix of full and skipped runs
    for (int i = 0; i < 8; i++) begin
      bit f;
      logic [NC-1:0] st;
      f = (i == 0) ? 1'b1 : 1'($urandom % 2);
      dly = int'($urandom % 21);
      st = NC'($urandom);
      if (i == 0) st[0] = 1'b1;
      stat = st;
      run_seq(f, f);
      exp_m = next_mask(exp_m, st, 1'b1);
      if (f) check_full_normal("rand");
      else begin
        chk(clr_cnt == 0, "R8", "rand skip no clear", clr_cnt, 0);
        chk(link_run == lr_before, "R8", "rand skip run bit unchanged", link_run, lr_before);
        chk(t_done >= 1 && t_done <= 3, "R8", "rand skip latency", t_done, 2);
        chk(done_cnt == 1, "R9", "rand skip single done", done_cnt, 1);
      end
      chk(mask == exp_m, "R7", "mask after run", mask, exp_m);
    end

    // readback stuck high: reset-phase poll times out
    stuck_hi = 1;
    run_seq(1'b1, 1'b0);
    stuck_hi = 0;
    chk(tmo == 1'b1, "R4", "enter timeout flag", tmo, 1);
    chk(done_cnt == 1 && t_done >= TMO, "R4", "sequence continues after timeout", t_done, TMO);
    chk(busy_err == 1'b0, "R6", "ready after enter timeout", busy_err, 0);
    chk(mask == exp_m, "R7", "mask kept after timeout run", mask, exp_m);

    // normal run clears the sticky flag
    dly = 0;
    repeat (40) @(negedge clk);
    run_seq(1'b1, 1'b0);
    check_full_normal("after timeout");

    // readback stuck low: run-phase poll times out, not ready at check
    stuck_lo = 1;
    stat = ~exp_m;
    run_seq(1'b1, 1'b0);
    chk(tmo == 1'b1, "R4", "exit timeout flag", tmo, 1);
    chk(busy_err == 1'b1, "R6", "busy after exit timeout", busy_err, 1);
    chk(mask == exp_m, "R7", "mask kept when not ready", mask, exp_m);
    stuck_lo = 0;
    repeat (40) @(negedge clk);
    run_seq(1'b0, 1'b0);
    chk(busy_err == 1'b0, "R6", "busy cleared by next start", busy_err, 0);
    chk(tmo == 1'b0, "R4", "timeout cleared by next start", tmo, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule